// File: doc/BRIEF.md
# Serial Clock Divider With Guard Delays

This block derives a slow serial clock from the bus clock and frames each serial transaction with two programmable guard intervals. A one-cycle start strobe launches a transaction; the block then runs a leading guard interval, a fixed transfer window of sixteen serial clocks, and a trailing guard interval, all measured in serial clock periods. A busy flag covers the whole sequence and a one-cycle done strobe marks its end. The data shifter that uses the transfer window sits outside this block.

The timing fields (a 3-bit ratio, a 3-bit leading guard and a 4-bit trailing guard) come in from the register bank. Two zero values would stall the bus side, so on acceptance of a start the block substitutes safe values: a zero ratio becomes 7 and a zero trailing guard becomes 1. The values actually in use are driven out on `act_ratio` and `act_guard2` so the register bank can show the corrected fields. A leading guard of zero is legal and skips that phase.

Top module: `sclk_guard_gen`

## Requirements
- R1: After reset, `sclk`, `busy`, `done` and `xfer_active` are 0, `act_ratio` is 7 and `act_guard2` is 1.
- R2: A start accepted with a nonzero ratio N drives `act_ratio` to N from the next cycle on.
- R3: A start accepted with a zero ratio drives `act_ratio` to 7, and the transaction runs with ratio 7.
- R4: A start accepted with a zero trailing guard drives `act_guard2` to 1 and runs a one-period trailing guard; a nonzero value is used unchanged.
- R5: While busy, `sclk` starts low and each of its levels lasts N+1 bus cycles, where N is the effective ratio; while idle `sclk` is low.
- R6: `busy` is high for exactly (G1 + 16 + G2) * 2 * (N+1) bus cycles, counted from the cycle after the start is accepted, where G1 and G2 are the effective guard values.
- R7: `done` is high for exactly one bus cycle, the first cycle in which `busy` is low again.
- R8: A start strobe while `busy` is high is ignored, and changes to the timing fields during a transaction do not affect it: `act_ratio`, `act_guard2` and the busy length stay those of the accepted start.
- R9: The phases run in the order leading guard, transfer, trailing guard: `xfer_active` rises after G1 * 2 * (N+1) busy cycles and stays high for 32 * (N+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transaction start strobe |
| cfg_ratio | input | 3 | Division ratio field |
| cfg_guard1 | input | 3 | Leading guard, serial clock periods |
| cfg_guard2 | input | 4 | Trailing guard, serial clock periods |
| sclk | output | 1 | Divided serial clock |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| xfer_active | output | 1 | Transfer window active |
| act_ratio | output | 3 | Ratio in use (after substitution) |
| act_guard2 | output | 4 | Trailing guard in use (after substitution) |

## Verification
Transactions are launched with several ratio and guard combinations: small nonzero values, a zero ratio together with a zero trailing guard, a zero leading guard, and the largest trailing guard. Comparing measured busy length, transfer-window offset and length, and the first serial clock high time separates the substitution paths from the ordinary ones and shows whether the divider and the phase counter agree on the serial period. One run pulses start and rewrites the fields mid-transaction, which tells an ignored strobe apart from a restart or a live re-read of the configuration.

// File: rtl/sgg_pkg.sv
package sgg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_XFER  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_t;

  // Replace an illegal zero with a safe fallback
  function automatic int unsigned safe_value(input int unsigned v, input int unsigned fallback);
    return (v == 0) ? fallback : v;
  endfunction

  // Bus cycles per serial clock period for a given ratio
  function automatic int unsigned serial_period(input int unsigned ratio);
    return 2 * (ratio + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sgg_cfg_latch.sv
module sgg_cfg_latch #(
  parameter int RATIO_W    = 3,
  parameter int G1_W       = 3,
  parameter int G2_W       = 4,
  parameter int RATIO_SAFE = 7,
  parameter int G2_SAFE    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [G1_W-1:0]    g1_in,
  input  logic [G2_W-1:0]    g2_in,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [G1_W-1:0]    g1_q,
  output logic [G2_W-1:0]    g2_q
);
  import sgg_pkg::*;

  logic [RATIO_W-1:0] ratio_fix;
  logic [G2_W-1:0]    g2_fix;

  always_comb begin
    ratio_fix = RATIO_W'(safe_value(int'(ratio_in), RATIO_SAFE));
    g2_fix    = G2_W'(safe_value(int'(g2_in), G2_SAFE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(RATIO_SAFE);
      g1_q    <= '0;
      g2_q    <= G2_W'(G2_SAFE);
    end else if (accept) begin
      ratio_q <= ratio_fix;
      g1_q    <= g1_in;
      g2_q    <= g2_fix;
    end
  end

  assert_ratio_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q != '0);

  assert_ratio_subst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ratio_in == '0 |=> ratio_q == RATIO_W'(RATIO_SAFE));

  assert_guard2_subst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && g2_in == '0 |=> g2_q == G2_W'(G2_SAFE));

  assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ratio_q) && $stable(g2_q) && $stable(g1_q));

endmodule

// File: rtl/sgg_divider.sv
module sgg_divider #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sclk,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt;
  logic               wrap;

  assign wrap = (cnt == ratio);
  // a serial period ends when sclk is about to fall
  assign tick = run && sclk && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

  assert_tick_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !sclk);

  assert_toggle_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wrap |=> $stable(sclk));

endmodule

// File: rtl/sgg_sequencer.sv
module sgg_sequencer #(
  parameter int G1_W     = 3,
  parameter int G2_W     = 4,
  parameter int XFER_LEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [G1_W-1:0] g1_now,
  input  logic [G1_W-1:0] g1_q,
  input  logic [G2_W-1:0] g2_q,
  output logic            accept,
  output logic            busy,
  output logic            done,
  output logic            xfer_active
);
  import sgg_pkg::*;

  localparam int MAX_LEN = max2(max2(XFER_LEN, 2 ** G2_W), 2 ** G1_W);
  localparam int CNT_W   = $clog2(MAX_LEN) + 1;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             phase_last;

  always_comb begin
    unique case (phase)
      PH_LEAD:  limit = CNT_W'(g1_q);
      PH_XFER:  limit = CNT_W'(XFER_LEN);
      PH_TRAIL: limit = CNT_W'(g2_q);
      default:  limit = '0;
    endcase
  end

  assign accept      = start && (phase == PH_IDLE);
  assign phase_last  = tick && (cnt == limit - 1'b1);
  assign busy        = (phase != PH_IDLE);
  assign xfer_active = (phase == PH_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase <= (g1_now == '0) ? PH_XFER : PH_LEAD;
        cnt   <= '0;
      end else if (phase_last) begin
        cnt <= '0;
        unique case (phase)
          PH_LEAD:  phase <= PH_XFER;
          PH_XFER:  phase <= PH_TRAIL;
          PH_TRAIL: begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
          default:  phase <= PH_IDLE;
        endcase
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_xfer_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> $past(phase) == PH_LEAD || $past(phase) == PH_IDLE);

  assert_trail_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_active) |-> phase == PH_TRAIL);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !phase_last |=> busy);

endmodule

// File: rtl/sclk_guard_gen.sv
module sclk_guard_gen #(
  parameter int RATIO_W    = 3,
  parameter int G1_W       = 3,
  parameter int G2_W       = 4,
  parameter int XFER_LEN   = 16,
  parameter int RATIO_SAFE = 7,
  parameter int G2_SAFE    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [G1_W-1:0]    cfg_guard1,
  input  logic [G2_W-1:0]    cfg_guard2,
  output logic               sclk,
  output logic               busy,
  output logic               done,
  output logic               xfer_active,
  output logic [RATIO_W-1:0] act_ratio,
  output logic [G2_W-1:0]    act_guard2
);
  logic            accept;
  logic            tick;
  logic [G1_W-1:0] act_guard1;

  sgg_cfg_latch #(
    .RATIO_W(RATIO_W), .G1_W(G1_W), .G2_W(G2_W),
    .RATIO_SAFE(RATIO_SAFE), .G2_SAFE(G2_SAFE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .ratio_in(cfg_ratio), .g1_in(cfg_guard1), .g2_in(cfg_guard2),
    .ratio_q(act_ratio), .g1_q(act_guard1), .g2_q(act_guard2)
  );

  sgg_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .ratio(act_ratio),
    .sclk(sclk), .tick(tick)
  );

  sgg_sequencer #(.G1_W(G1_W), .G2_W(G2_W), .XFER_LEN(XFER_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .g1_now(cfg_guard1), .g1_q(act_guard1), .g2_q(act_guard2),
    .accept(accept), .busy(busy), .done(done), .xfer_active(xfer_active)
  );

  assert_busy_keeps_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(act_ratio) && $stable(act_guard2));

  assert_xfer_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> $past(busy) || $past(accept));

  assert_start_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !sclk);

endmodule

// File: tb/sclk_guard_gen_bench.sv
module sclk_guard_gen_bench;

  typedef struct {
    int unsigned ratio;
    int unsigned g2;
    int unsigned busy_len;
    int unsigned xfer_off;
    int unsigned xfer_len;
    int unsigned hi_len;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cfg_ratio = '0;
  logic [2:0] cfg_guard1 = '0;
  logic [3:0] cfg_guard2 = '0;
  logic       sclk, busy, done, xfer_active;
  logic [2:0] act_ratio;
  logic [3:0] act_guard2;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  sclk_guard_gen u_sclk_guard_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_ratio(cfg_ratio), .cfg_guard1(cfg_guard1), .cfg_guard2(cfg_guard2),
    .sclk(sclk), .busy(busy), .done(done), .xfer_active(xfer_active),
    .act_ratio(act_ratio), .act_guard2(act_guard2)
  );

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int unsigned r, input int unsigned g1, input int unsigned g2,
                         input bit poke);
    exp_t e;
    int unsigned re, ge, per;
    re  = (r == 0) ? 7 : r;
    ge  = (g2 == 0) ? 1 : g2;
    per = 2 * (re + 1);
    e.ratio    = re;
    e.g2       = ge;
    e.busy_len = (g1 + 16 + ge) * per;
    e.xfer_off = g1 * per;
    e.xfer_len = 16 * per;
    e.hi_len   = re + 1;
    sb.push_back(e);
    cfg_ratio  = 3'(r);
    cfg_guard1 = 3'(g1);
    cfg_guard2 = 4'(g2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      cfg_ratio  = 3'(r ^ 3'd5);
      cfg_guard1 = 3'd0;
      cfg_guard2 = 4'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  int unsigned busy_cnt = 0, xfer_off = 0, xfer_cnt = 0, hi_cnt = 0;
  bit xfer_seen = 0, hi_closed = 0, prev_done = 0, prev_busy = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy) begin
        busy_cnt++;
        if (xfer_active) begin
          if (!xfer_seen) xfer_off = busy_cnt - 1;
          xfer_seen = 1;
          xfer_cnt++;
        end
        if (sclk && !hi_closed) hi_cnt++;
        else if (!sclk && hi_cnt > 0) hi_closed = 1;
      end
      if (done && prev_done) check("R7 done width", 2, 1);
      if (done) begin
        check("R7 busy low with done", busy, 0);
        check("R7 busy high before done", prev_busy, 1);
        check("R5 sclk idle low", sclk, 0);
        if (sb.size() == 0) begin
          check("R6 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.ratio == 7 ? "R3 act_ratio" : "R2 act_ratio", act_ratio, e.ratio);
          check("R4 act_guard2", act_guard2, e.g2);
          check("R6 R8 busy length", busy_cnt, e.busy_len);
          check("R9 xfer offset", xfer_off, e.xfer_off);
          check("R9 xfer length", xfer_cnt, e.xfer_len);
          check("R5 sclk high time", hi_cnt, e.hi_len);
        end
        busy_cnt = 0; xfer_off = 0; xfer_cnt = 0; hi_cnt = 0;
        xfer_seen = 0; hi_closed = 0;
      end
      prev_done = done;
      prev_busy = busy;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sclk", sclk, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 xfer_active", xfer_active, 0);
    check("R1 act_ratio", act_ratio, 7);
    check("R1 act_guard2", act_guard2, 1);
    run_txn(3, 2, 6, 0);
    run_txn(0, 1, 0, 0);   // both substitutions
    run_txn(1, 0, 8, 0);   // leading guard skipped
    run_txn(2, 3, 15, 1);  // start and field changes while busy
    run_txn(5, 7, 1, 0);
    check("R6 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule